// File: doc/BRIEF.md
# Integer/Float Conversion Unit

This unit converts in both directions between 32-bit signed two's-complement integers and IEEE-754 single-precision values. One operation code chooses the direction. A 2-bit rounding mode, taken from the floating-point control field, governs rounding in both directions. Each result comes back with a two-bit exception vector: invalid and inexact.

Requests arrive on a valid/ready port that accepts one operation on every cycle. The pipeline has two stages. The first stage unpacks the operand into a common form: sign, kept integer field, round bit and sticky bit. The second stage holds a single rounding incrementer that both directions share, then applies the sign and widens the value to the register width `XLEN`. A float-to-integer result is sign-extended. An integer-to-float result is zero-extended.

The unit has no state machine. Its only sequencing is the two-stage valid pipeline: stage 1 is loaded on every accepted request, stage 2 is loaded from stage 1, and the response is driven from stage 2.

Top module: `int_float_cvt`

## Requirements
- R1: `req_ready` is high whenever reset is released. Each request accepted at a clock edge produces a one-cycle `rsp_valid` pulse exactly 2 cycles later. Back-to-back requests give back-to-back responses in order.
- R2: Operation code 0x04 converts the signed integer on `req_src_a` to single precision, rounded by `req_rmode`. The rounding codes are: 0 = nearest, ties to even; 1 = toward zero; 2 = toward +infinity; 3 = toward -infinity.
- R3: Operation code 0x05 converts the single-precision value on `req_src_a` to a signed 32-bit integer, rounded by `req_rmode` using the same code meanings as R2.
- R4: A float-to-integer result is sign-extended from bit 31 up to `XLEN` bits. An integer-to-float result has zero in every bit above bit 31.
- R5: `rsp_flags[0]` (inexact) is set whenever a conversion discards nonzero bits, in either direction. It is never set together with `rsp_flags[1]`.
- R6: Float-to-integer saturates and sets `rsp_flags[1]` (invalid) in these cases: NaN, +inf and positive overflow give 0x7FFFFFFF; -inf and negative overflow give 0x80000000. An exact -2^31 input converts without any flag.
- R7: Integer 0 converts to +0.0. Both +0.0 and -0.0 convert to integer 0. No flag is set in either case.
- R8: A subnormal input to float-to-integer is treated as a tiny nonzero magnitude. It gives 0, +1 or -1 according to the rounding mode and sign, and it sets inexact.
- R9: The second source operand `req_src_b` has no effect on the result or the flags.
- R10: Any other operation code still produces a response after 2 cycles, with result 0 and flags 0.
- R11: While reset is asserted, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request (always high out of reset) |
| req_op | input | 8 | Operation code: 0x04 integer to float, 0x05 float to integer |
| req_rmode | input | 2 | Rounding mode, coded as in R2 |
| req_src_a | input | 32 | Operand: an integer or a single-precision value |
| req_src_b | input | 32 | Second source field, ignored |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_result | output | XLEN | Converted value, widened to the register width |
| rsp_flags | output | 2 | Bit 1 invalid, bit 0 inexact |

## Verification
The bench targets the following corner cases:
- Ties under nearest-even, such as 2.5, -2.5, 3.5 and 2^24+1. A unit that rounded half away from zero would return 3 or 2^24+2 instead.
- Directed rounding of negative values. Here a design that added the increment to the two's-complement value instead of to the magnitude would round -2.5 the wrong way.
- The saturation boundary at ±2^31. The exact value -2^31 must pass through unflagged while 2^31 saturates. NaN and the infinities must saturate with the invalid flag.
- Subnormals, ±0.0, an operation code outside the two supported ones, and a varying `req_src_b`. These catch a unit that flushes subnormals without honouring the mode, loses the sign on widening, or lets the ignored operand leak into the result.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 8;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int BIAS   = 127;

    localparam logic [OP_W-1:0] OP_INT_TO_FP = 8'h04;
    localparam logic [OP_W-1:0] OP_FP_TO_INT = 8'h05;

    localparam logic [WORD_W-1:0] INT_POS_SAT = 32'h7FFF_FFFF;
    localparam logic [WORD_W-1:0] INT_NEG_SAT = 32'h8000_0000;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_TO_POS    = 2'd2,
        RM_TO_NEG    = 2'd3
    } rmode_e;

    // Common intermediate form handed from stage 1 to the shared rounder.
    typedef struct packed {
        logic              to_int;    // result is an integer (sign-extend)
        logic              sign;
        logic [WORD_W-1:0] kept;      // magnitude or packed exp/mantissa before rounding
        logic              rnd;       // first discarded bit
        logic              stk;       // OR of the remaining discarded bits
        logic              special;   // kept/rnd/stk unused, take fixed_val
        logic [WORD_W-1:0] fixed_val;
        logic              fixed_inv;
        rmode_e            rm;
    } pre_t;

    function automatic logic [5:0] lead_zeros(input logic [WORD_W-1:0] v);
        logic [5:0] cnt;
        logic       seen;
        cnt  = '0;
        seen = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      cnt  = cnt + 6'd1;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/cvt_i2f_pre.sv
module cvt_i2f_pre
    import cvt_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  rmode_e            rm,
    output pre_t              pre
);
    localparam int TOP_EXP = BIAS + WORD_W - 1;

    logic              sgn;
    logic [WORD_W-1:0] mag;
    logic [5:0]        lz;
    logic [WORD_W-1:0] norm;
    logic [EXP_W-1:0]  bexp;
    logic              unused_norm_msb;

    always_comb begin
        sgn  = src[WORD_W-1];
        mag  = sgn ? (~src + 32'd1) : src;
        lz   = lead_zeros(mag);
        norm = mag << lz;
        bexp = EXP_W'(TOP_EXP) - {2'b00, lz};
    end

    assign unused_norm_msb = norm[WORD_W-1];

    always_comb begin
        pre           = '0;
        pre.to_int    = 1'b0;
        pre.rm        = rm;
        pre.sign      = sgn;
        pre.kept      = {1'b0, bexp, norm[WORD_W-2 -: MAN_W]};
        pre.rnd       = norm[WORD_W-2-MAN_W];
        pre.stk       = |norm[WORD_W-3-MAN_W:0];
        pre.special   = (mag == '0);
        pre.fixed_val = '0;
        pre.fixed_inv = 1'b0;
    end

endmodule

// File: rtl/cvt_f2i_pre.sv
module cvt_f2i_pre
    import cvt_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  rmode_e            rm,
    output pre_t              pre
);
    localparam int SIG_W     = MAN_W + 1;
    localparam int WIDE_W    = SIG_W + WORD_W;
    localparam int EXP_UNIT  = BIAS + MAN_W;        // exponent where LSB weighs 1
    localparam int EXP_LIMIT = BIAS + WORD_W - 1;   // exponent of 2^31
    localparam int EXP_TINY  = BIAS - 2;            // below this: under a quarter

    logic              sgn;
    logic [EXP_W-1:0]  bexp;
    logic [MAN_W-1:0]  frac;
    logic [SIG_W-1:0]  sig;
    logic [EXP_W-1:0]  lsh;
    logic [EXP_W-1:0]  rsh;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        sgn  = src[WORD_W-1];
        bexp = src[WORD_W-2 -: EXP_W];
        frac = src[MAN_W-1:0];
        sig  = {1'b1, frac};
        lsh  = bexp - EXP_W'(EXP_UNIT);
        rsh  = EXP_W'(EXP_UNIT) - bexp;
        wide = {sig, {WORD_W{1'b0}}} >> rsh;
    end

    always_comb begin
        pre           = '0;
        pre.to_int    = 1'b1;
        pre.rm        = rm;
        pre.sign      = sgn;
        pre.fixed_val = '0;
        pre.fixed_inv = 1'b0;
        if (bexp == '1) begin
            pre.special   = 1'b1;
            pre.fixed_inv = 1'b1;
            pre.fixed_val = (frac != '0) ? INT_POS_SAT : (sgn ? INT_NEG_SAT : INT_POS_SAT);
        end else if (bexp == '0) begin
            if (frac == '0) begin
                pre.special = 1'b1;
            end else begin
                pre.stk = 1'b1;
            end
        end else if ((bexp > EXP_W'(EXP_LIMIT)) ||
                     ((bexp == EXP_W'(EXP_LIMIT)) && !(sgn && frac == '0))) begin
            pre.special   = 1'b1;
            pre.fixed_inv = 1'b1;
            pre.fixed_val = sgn ? INT_NEG_SAT : INT_POS_SAT;
        end else if (bexp >= EXP_W'(EXP_UNIT)) begin
            pre.kept = WORD_W'(sig) << lsh;
        end else if (bexp >= EXP_W'(EXP_TINY)) begin
            pre.kept = WORD_W'(wide[WIDE_W-1 -: SIG_W]);
            pre.rnd  = wide[WORD_W-1];
            pre.stk  = |wide[WORD_W-2:0];
        end else begin
            pre.stk = 1'b1;
        end
    end

endmodule

// File: rtl/cvt_round.sv
module cvt_round
    import cvt_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  pre_t            pre,
    output logic [XLEN-1:0] result,
    output logic [1:0]      flags
);
    localparam int EXT_W = XLEN - WORD_W;

    logic              inc;
    logic              lost;
    logic [WORD_W-1:0] mag;
    logic [WORD_W-1:0] word;

    always_comb begin
        lost = pre.rnd | pre.stk;
        unique case (pre.rm)
            RM_NEAR_EVEN: inc = pre.rnd & (pre.stk | pre.kept[0]);
            RM_TO_ZERO:   inc = 1'b0;
            RM_TO_POS:    inc = ~pre.sign & lost;
            RM_TO_NEG:    inc = pre.sign & lost;
        endcase
        mag = pre.kept + WORD_W'(inc);
    end

    always_comb begin
        if (pre.special) begin
            word  = pre.fixed_val;
            flags = {pre.fixed_inv, 1'b0};
        end else if (pre.to_int) begin
            word  = pre.sign ? (~mag + 32'd1) : mag;
            flags = {1'b0, lost};
        end else begin
            word  = {pre.sign, mag[WORD_W-2:0]};
            flags = {1'b0, lost};
        end
    end

    generate
        if (EXT_W > 0) begin : g_widen
            assign result = {{EXT_W{word[WORD_W-1] & pre.to_int}}, word};
        end else begin : g_narrow
            assign result = word;
        end
    endgenerate

endmodule

// File: rtl/int_float_cvt.sv
module int_float_cvt
    import cvt_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [7:0]      req_op,
    input  logic [1:0]      req_rmode,
    input  logic [31:0]     req_src_a,
    input  logic [31:0]     req_src_b,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_result,
    output logic [1:0]      rsp_flags
);
    pre_t            i2f_pre;
    pre_t            f2i_pre;
    pre_t            sel_pre;
    pre_t            s1_pre;
    logic            s1_valid;
    logic [XLEN-1:0] rnd_result;
    logic [1:0]      rnd_flags;
    logic            unused_src_b;

    assign req_ready    = 1'b1;
    assign unused_src_b = ^req_src_b;

    cvt_i2f_pre i_i2f_pre (
        .src (req_src_a),
        .rm  (rmode_e'(req_rmode)),
        .pre (i2f_pre)
    );

    cvt_f2i_pre i_f2i_pre (
        .src (req_src_a),
        .rm  (rmode_e'(req_rmode)),
        .pre (f2i_pre)
    );

    always_comb begin
        if (req_op == OP_FP_TO_INT) begin
            sel_pre = f2i_pre;
        end else if (req_op == OP_INT_TO_FP) begin
            sel_pre = i2f_pre;
        end else begin
            sel_pre         = '0;
            sel_pre.special = 1'b1;
        end
    end

    // Stage 1: unpacked operand
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pre   <= '0;
        end else begin
            s1_valid <= req_valid & req_ready;
            if (req_valid & req_ready) s1_pre <= sel_pre;
        end
    end

    cvt_round #(.XLEN(XLEN)) i_round (
        .pre    (s1_pre),
        .result (rnd_result),
        .flags  (rnd_flags)
    );

    // Stage 2: rounded, widened response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_result <= '0;
            rsp_flags  <= '0;
        end else begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_result <= rnd_result;
                rsp_flags  <= rnd_flags;
            end
        end
    end

endmodule

// File: rtl/cvt_chk.sv
module cvt_chk
    import cvt_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [7:0]      req_op,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_result,
    input logic [1:0]      rsp_flags
);
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);                         // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));                                  // R1

    AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_op, 2) == OP_FP_TO_INT)
        |-> (rsp_result == XLEN'($signed(rsp_result[31:0]))));               // R4

    AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_op, 2) == OP_INT_TO_FP)
        |-> (rsp_result == XLEN'(rsp_result[31:0])));                        // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(rsp_flags));                                  // R5

    AST_INVALID_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_flags[1])
        |-> (rsp_result[31:0] == INT_POS_SAT || rsp_result[31:0] == INT_NEG_SAT)); // R6

    AST_I2F_NEVER_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_op, 2) == OP_INT_TO_FP) |-> !rsp_flags[1]); // R2

endmodule

bind int_float_cvt cvt_chk #(.XLEN(XLEN)) i_cvt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_result (rsp_result),
    .rsp_flags  (rsp_flags)
);

// File: tb/test_int_float_cvt.sv
`timescale 1ns/1ps
module test_int_float_cvt;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [7:0]      req_op = '0;
    logic [1:0]      req_rmode = '0;
    logic [31:0]     req_src_a = '0;
    logic [31:0]     req_src_b = '0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_result;
    logic [1:0]      rsp_flags;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic [1:0]  flg;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    int_float_cvt #(.XLEN(XLEN)) i_int_float_cvt (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_rmode  (req_rmode),
        .req_src_a  (req_src_a),
        .req_src_b  (req_src_b),
        .rsp_valid  (rsp_valid),
        .rsp_result (rsp_result),
        .rsp_flags  (rsp_flags)
    );

    // ---------------- reference models ----------------
    function automatic logic round_up(logic s, logic q0, longint rem, longint half, logic [1:0] rm);
        case (rm)
            2'd0: return (rem > half) || (rem == half && rem != 0 && q0);
            2'd1: return 1'b0;
            2'd2: return !s && rem != 0;
            default: return s && rem != 0;
        endcase
    endfunction

    function automatic logic [65:0] ref_i2f(logic [31:0] a, logic [1:0] rm);
        logic s; longint m, q, rem, half; int p;
        logic [7:0] ex;
        s = a[31];
        m = s ? -longint'($signed(a)) : longint'(a);
        if (m == 0) return '0;
        p = 0;
        for (int i = 0; i < 32; i++) if (m[i]) p = i;
        if (p <= 23) begin
            q = m << (23 - p); rem = 0; half = 1;
        end else begin
            q = m >> (p - 23);
            rem = m - (q << (p - 23));
            half = longint'(1) << (p - 24);
        end
        q = q + longint'(round_up(s, q[0], rem, half, rm));
        if (q == (longint'(1) << 24)) begin q = q >> 1; p = p + 1; end
        ex = 8'(p + 127);
        return {1'b0, rem != 0, 32'h0, s, ex, q[22:0]};
    endfunction

    function automatic logic [65:0] ref_f2i(logic [31:0] a, logic [1:0] rm);
        logic s; int ex, e, n; longint m, q, rem, half, val;
        logic [63:0] sat;
        s   = a[31];
        ex  = int'(a[30:23]);
        sat = s ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
        if (ex == 255) return {2'b10, (a[22:0] != 0) ? 64'h7FFF_FFFF : sat};
        if (ex == 0 && a[22:0] == 0) return '0;
        m = longint'(a[22:0]);
        if (ex != 0) m = m + (longint'(1) << 23);
        e = (ex == 0) ? -149 : ex - 150;
        if (e >= 10) return {2'b10, sat};
        if (e >= 0) begin
            q = m << e; rem = 0; half = 1;
        end else begin
            n = -e;
            if (n >= 40) begin q = 0; rem = 1; half = 2; end
            else begin
                q = m >> n; rem = m - (q << n); half = longint'(1) << (n - 1);
            end
        end
        q = q + longint'(round_up(s, q[0], rem, half, rm));
        val = s ? -q : q;
        if (val > 64'sd2147483647 || val < -64'sd2147483648) return {2'b10, sat};
        return {1'b0, rem != 0, 64'(val)};
    endfunction

    // ---------------- driver ----------------
    task automatic push_req(logic [7:0] op, logic [1:0] rm, logic [31:0] a, logic [31:0] b,
                            logic [63:0] er, logic [1:0] ef, string tag);
        exp_t it;
        it.res = er; it.flg = ef; it.due = cyc + 2; it.tag = tag;
        sb.push_back(it);
        req_valid = 1'b1; req_op = op; req_rmode = rm; req_src_a = a; req_src_b = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ref(logic [7:0] op, logic [1:0] rm, logic [31:0] a, logic [31:0] b, string tag);
        logic [65:0] r;
        if (op == 8'h04)      r = ref_i2f(a, rm);
        else if (op == 8'h05) r = ref_f2i(a, rm);
        else                  r = '0;
        push_req(op, rm, a, b, r[63:0], r[65:64], tag);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected response: got %h, expected none", rsp_result);
            end else begin
                exp_t it;
                it = sb.pop_front();
                if (cyc != it.due) begin
                    fails++;
                    $display("FAIL R1 %s latency: got cycle %0d, expected %0d", it.tag, cyc, it.due);
                end
                if (rsp_result !== it.res || rsp_flags !== it.flg) begin
                    fails++;
                    $display("FAIL %s: got %h/%b, expected %h/%b", it.tag, rsp_result, rsp_flags, it.res, it.flg);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: got rsp_valid=%b, expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 ready: got %b, expected 1", req_ready);
        end

        // R2 / R7: integer to float, directed
        push_req(8'h04, 2'd0, 32'd0,        32'h0, 64'h0,         2'b00, "R7 int 0");
        push_req(8'h04, 2'd0, 32'd1,        32'h0, 64'h3F80_0000, 2'b00, "R2 int 1");
        push_req(8'h04, 2'd0, 32'hFFFF_FFFF, 32'h0, 64'hBF80_0000, 2'b00, "R4 int -1 zero-ext");
        push_req(8'h04, 2'd0, 32'd16777217, 32'h0, 64'h4B80_0000, 2'b01, "R2 tie even");
        push_req(8'h04, 2'd2, 32'd16777217, 32'h0, 64'h4B80_0001, 2'b01, "R2 to +inf");
        push_req(8'h04, 2'd0, 32'h7FFF_FFFF, 32'h0, 64'h4F00_0000, 2'b01, "R5 max int nearest");
        push_req(8'h04, 2'd1, 32'h7FFF_FFFF, 32'h0, 64'h4EFF_FFFF, 2'b01, "R2 max int to zero");
        push_req(8'h04, 2'd0, 32'h8000_0000, 32'h0, 64'hCF00_0000, 2'b00, "R2 min int exact");
        push_req(8'h04, 2'd3, 32'hFEFF_FFFF, 32'h0, 64'hCB80_0001, 2'b01, "R2 neg to -inf");
        push_req(8'h04, 2'd2, 32'hFEFF_FFFF, 32'h0, 64'hCB80_0000, 2'b01, "R2 neg to +inf");

        // R3 / R6 / R7 / R8: float to integer, directed
        push_req(8'h05, 2'd0, 32'h4020_0000, 32'h0, 64'd2, 2'b01, "R3 2.5 nearest");
        push_req(8'h05, 2'd1, 32'h4020_0000, 32'h0, 64'd2, 2'b01, "R3 2.5 to zero");
        push_req(8'h05, 2'd2, 32'h4020_0000, 32'h0, 64'd3, 2'b01, "R3 2.5 to +inf");
        push_req(8'h05, 2'd3, 32'h4020_0000, 32'h0, 64'd2, 2'b01, "R3 2.5 to -inf");
        push_req(8'h05, 2'd0, 32'hC020_0000, 32'h0, 64'hFFFF_FFFF_FFFF_FFFE, 2'b01, "R3 -2.5 nearest");
        push_req(8'h05, 2'd3, 32'hC020_0000, 32'h0, 64'hFFFF_FFFF_FFFF_FFFD, 2'b01, "R3 -2.5 to -inf");
        push_req(8'h05, 2'd0, 32'h4060_0000, 32'h0, 64'd4, 2'b01, "R3 3.5 nearest");
        push_req(8'h05, 2'd2, 32'h3F00_0000, 32'h0, 64'd1, 2'b01, "R3 0.5 to +inf");
        push_req(8'h05, 2'd0, 32'hC2F6_0000, 32'h0, 64'hFFFF_FFFF_FFFF_FF85, 2'b00, "R4 -123 sign-ext");
        push_req(8'h05, 2'd0, 32'h7FC0_0000, 32'h0, 64'h7FFF_FFFF, 2'b10, "R6 NaN");
        push_req(8'h05, 2'd0, 32'h7F80_0000, 32'h0, 64'h7FFF_FFFF, 2'b10, "R6 +inf");
        push_req(8'h05, 2'd0, 32'hFF80_0000, 32'h0, 64'hFFFF_FFFF_8000_0000, 2'b10, "R6 -inf");
        push_req(8'h05, 2'd0, 32'h4F00_0000, 32'h0, 64'h7FFF_FFFF, 2'b10, "R6 2^31 overflow");
        push_req(8'h05, 2'd0, 32'hCF00_0000, 32'h0, 64'hFFFF_FFFF_8000_0000, 2'b00, "R6 exact -2^31");
        push_req(8'h05, 2'd0, 32'hCF00_0001, 32'h0, 64'hFFFF_FFFF_8000_0000, 2'b10, "R6 below -2^31");
        push_req(8'h05, 2'd0, 32'h0000_0000, 32'h0, 64'h0, 2'b00, "R7 +0.0");
        push_req(8'h05, 2'd3, 32'h8000_0000, 32'h0, 64'h0, 2'b00, "R7 -0.0");
        push_req(8'h05, 2'd2, 32'h0000_0001, 32'h0, 64'd1, 2'b01, "R8 subnormal to +inf");
        push_req(8'h05, 2'd0, 32'h0000_0001, 32'h0, 64'd0, 2'b01, "R8 subnormal nearest");
        push_req(8'h05, 2'd3, 32'h8000_0001, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, "R8 neg subnormal to -inf");
        push_req(8'h05, 2'd2, 32'h8000_0001, 32'h0, 64'd0, 2'b01, "R8 neg subnormal to +inf");

        // R9: second operand ignored
        push_req(8'h05, 2'd0, 32'h4060_0000, 32'hFFFF_FFFF, 64'd4, 2'b01, "R9 src_b ones f2i");
        push_req(8'h04, 2'd0, 32'd1, 32'hDEAD_BEEF, 64'h3F80_0000, 2'b00, "R9 src_b pattern i2f");

        // R10: unsupported codes
        push_req(8'h06, 2'd0, 32'h4060_0000, 32'h0, 64'h0, 2'b00, "R10 code 0x06");
        push_req(8'h00, 2'd2, 32'hFFFF_FFFF, 32'h0, 64'h0, 2'b00, "R10 code 0x00");

        // Random back-to-back traffic against the reference models
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [7:0]  ex;
            ex = 8'(100 + $urandom_range(0, 70));
            if (i % 2 == 0) begin
                a = $urandom;
                if (i % 8 == 0) a = a >> $urandom_range(0, 31);
                send_ref(8'h04, 2'($urandom_range(0, 3)), a, $urandom, "R2 random int to float");
            end else begin
                a = {1'($urandom_range(0, 1)), ex, 23'($urandom)};
                send_ref(8'h05, 2'($urandom_range(0, 3)), a, $urandom, "R3 random float to int");
            end
            if (i % 37 == 0) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 drain: got %0d pending, expected 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule